// File: doc/BRIEF.md
# Dual-Mode FIFO with Rewind

A single-clock first-in first-out buffer whose output timing is chosen when the block leaves master reset. In standard mode the reader pulls each word onto the output register with a read strobe, and the output holds its last value otherwise. In fall-through mode the oldest stored word is pushed onto the output register on its own and stays there until the reader takes it. The same reset-time choice changes the meaning of the two primary status flags. In standard mode they report empty and full. In fall-through mode they report output valid and room to write.

Three more flags work in both modes: half full, almost empty and almost full. The two "almost" thresholds come from offset inputs that a separate offset loader drives. A master reset sets the mode and clears the buffer. A partial reset clears the buffer but keeps the mode. A rewind strobe moves the read side back to the first storage location, so the words written since the last reset can be read a second time. All control inputs are active low and sampled on the rising clock edge.

Top module: `dual_mode_fifo`

## Requirements
- R1: The value on `fall_sel` at a rising edge with `mst_rst_n` low selects the mode (0 = standard, 1 = fall-through). That mode holds until the next master reset, whatever `fall_sel` does in between.
- R2: In standard mode, a write never changes `q_out` by itself. An edge with `rd_en_n` low and occupancy above zero places the oldest word on `q_out` after that edge. With `rd_en_n` high, `q_out` keeps its value.
- R3: In fall-through mode, a word written at edge k into a FIFO with nothing stored appears on `q_out`, with `empty_or_rdy` high, after edge k+1 and without any read. Each later word reaches `q_out` at the same edge on which the current one is read with `rd_en_n` low. Reading the last word drops `empty_or_rdy`.
- R4: `empty_or_rdy` is 1 in standard mode when occupancy is 0, and in fall-through mode when a valid word is on the output register. `full_or_room` is 1 in standard mode when occupancy equals DEPTH, and in fall-through mode when occupancy is below DEPTH.
- R5: `half_full` is 1 when occupancy is greater than DEPTH/2.
- R6: `almost_empty` is 1 when occupancy is at most `ae_ofs`. `almost_full` is 1 when occupancy is at least DEPTH minus `af_ofs`.
- R7: An edge with `mst_rst_n` low sets both pointers to location 0, occupancy to 0, the output register to zero and the valid indication to 0.
- R8: An edge with `prt_rst_n` low and `mst_rst_n` high has the same clearing effect as R7 but keeps the mode.
- R9: A write at full occupancy stores nothing. A read at zero occupancy in standard mode leaves `q_out` unchanged. Neither one moves a pointer.
- R10: An edge with `rewind_n` low and both resets high sets the read pointer to location 0 and occupancy to the write location index. It also clears the fall-through valid indication, and the word at location 0 is loaded again one edge later. Reads and writes on that edge are ignored.
- R11: With `out_en_n` high, `q_out` is all zeros. With it low, `q_out` shows the output register.
- R12: Occupancy counts the word held on the output register in fall-through mode until it is read. A write and a read accepted on the same edge leave occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write and read sides |
| mst_rst_n | input | 1 | Master reset, active low, synchronous; samples the mode |
| prt_rst_n | input | 1 | Partial reset, active low, synchronous; keeps the mode |
| fall_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read strobe, active low |
| rewind_n | input | 1 | Rewind read side to location 0, active low |
| out_en_n | input | 1 | Output enable, active low; zeros `q_out` when high |
| ae_ofs | input | $clog2(DEPTH) | Almost-empty threshold from the offset loader |
| af_ofs | input | $clog2(DEPTH) | Almost-full distance from full, from the offset loader |
| q_out | output | DATA_W | Output register, gated by `out_en_n` |
| empty_or_rdy | output | 1 | Empty (standard) or output valid (fall-through) |
| full_or_room | output | 1 | Full (standard) or room to write (fall-through) |
| half_full | output | 1 | Occupancy above half of DEPTH |
| almost_empty | output | 1 | Occupancy at or below `ae_ofs` |
| almost_full | output | 1 | Occupancy at or above DEPTH minus `af_ofs` |

## Verification
The hardest state to reach is a rewind that lands while fall-through mode has a word on the output register and the write pointer has already wrapped. The occupancy then jumps to the write index, and the valid word is thrown away and reloaded from location 0. Long random runs in each mode, with a write rate above the read rate, push the pointers around the storage several times between rare partial resets. Occasional rewind strobes then hit these wrapped, partly read states. Directed sequences cover the one-edge fall-through latency, a full-buffer write and the mode being kept across a partial reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FALL = 1'b1
   } dmf_mode_e;
endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   logic [DATA_W-1:0] cells [DEPTH];

   // one register row per location, each with its own decoded enable
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == AW'(gi))) begin
            cells[gi] <= wr_word;
         end
      end
   end

   assign rd_word = cells[rd_addr];
endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
   import dmf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          mst_rst_n,
   input  logic          prt_rst_n,
   input  logic          fall_sel,
   input  logic          wr_en_n,
   input  logic          rd_en_n,
   input  logic          rewind_n,
   input  logic          out_valid,
   output dmf_mode_e     mode_q,
   output logic          wr_ok,
   output logic          pop,
   output logic          drop,
   output logic          clr,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic [CW-1:0] count
);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   logic          live;
   logic          consume;
   logic [CW-1:0] mem_words;

   always_comb begin
      clr       = !mst_rst_n || !prt_rst_n;
      live      = !clr && rewind_n;
      wr_ok     = live && !wr_en_n && (count != FULL_C);
      mem_words = count - CW'(out_valid);
      if (mode_q == MODE_STD) begin
         consume = live && !rd_en_n && (count != '0);
         pop     = consume;
         drop    = 1'b0;
      end else begin
         consume = live && !rd_en_n && out_valid;
         pop     = live && (mem_words != '0) && (!out_valid || consume);
         drop    = (consume && !pop) || (!clr && !rewind_n);
      end
   end

   // mode follows the select pin only while master reset is held
   always_ff @(posedge clk) begin
      if (!mst_rst_n) begin
         mode_q <= fall_sel ? MODE_FALL : MODE_STD;
      end
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (!rewind_n) begin
         rd_ptr <= '0;
         count  <= CW'(wr_ptr);
      end else begin
         if (wr_ok) begin
            wr_ptr <= wr_ptr + 1'b1;
         end
         if (pop) begin
            rd_ptr <= rd_ptr + 1'b1;
         end
         count <= count + CW'(wr_ok) - CW'(consume);
      end
   end
endmodule

// File: rtl/dmf_outreg.sv
module dmf_outreg #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              load,
   input  logic              drop,
   input  logic [DATA_W-1:0] word_in,
   output logic [DATA_W-1:0] data_q,
   output logic              valid_q
);
   always_ff @(posedge clk) begin
      if (clr) begin
         data_q  <= '0;
         valid_q <= 1'b0;
      end else if (load) begin
         data_q  <= word_in;
         valid_q <= 1'b1;
      end else if (drop) begin
         valid_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
   import dmf_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  dmf_mode_e     mode,
   input  logic [CW-1:0] count,
   input  logic          out_valid,
   input  logic [AW-1:0] ae_ofs,
   input  logic [AW-1:0] af_ofs,
   output logic          sts_a,
   output logic          sts_b,
   output logic          half,
   output logic          near_empty,
   output logic          near_full
);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
   localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

   logic [CW-1:0] af_thr;

   always_comb begin
      af_thr     = FULL_C - CW'(af_ofs);
      half       = count > HALF_C;
      near_empty = count <= CW'(ae_ofs);
      near_full  = count >= af_thr;
      if (mode == MODE_STD) begin
         sts_a = (count == '0);
         sts_b = (count == FULL_C);
      end else begin
         sts_a = out_valid;
         sts_b = (count != FULL_C);
      end
   end
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
   import dmf_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              mst_rst_n,
   input  logic              prt_rst_n,
   input  logic              fall_sel,
   input  logic              wr_en_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en_n,
   input  logic              rewind_n,
   input  logic              out_en_n,
   input  logic [AW-1:0]     ae_ofs,
   input  logic [AW-1:0]     af_ofs,
   output logic [DATA_W-1:0] q_out,
   output logic              empty_or_rdy,
   output logic              full_or_room,
   output logic              half_full,
   output logic              almost_empty,
   output logic              almost_full
);
   if (DATA_W < 1) begin : g_bad_width
      $error("dual_mode_fifo: DATA_W must be positive");
   end
   if ((DEPTH < 4) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("dual_mode_fifo: DEPTH must be a power of two, at least 4");
   end

   dmf_mode_e         mode_q;
   logic              wr_ok;
   logic              pop;
   logic              drop;
   logic              clr;
   logic [AW-1:0]     wr_ptr;
   logic [AW-1:0]     rd_ptr;
   logic [CW-1:0]     count;
   logic [DATA_W-1:0] head_word;
   logic [DATA_W-1:0] data_q;
   logic              valid_q;

   dmf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk       (clk),
      .mst_rst_n (mst_rst_n),
      .prt_rst_n (prt_rst_n),
      .fall_sel  (fall_sel),
      .wr_en_n   (wr_en_n),
      .rd_en_n   (rd_en_n),
      .rewind_n  (rewind_n),
      .out_valid (valid_q),
      .mode_q    (mode_q),
      .wr_ok     (wr_ok),
      .pop       (pop),
      .drop      (drop),
      .clr       (clr),
      .wr_ptr    (wr_ptr),
      .rd_ptr    (rd_ptr),
      .count     (count)
   );

   dmf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
      .clk     (clk),
      .wr_en   (wr_ok),
      .wr_addr (wr_ptr),
      .wr_word (wr_data),
      .rd_addr (rd_ptr),
      .rd_word (head_word)
   );

   dmf_outreg #(.DATA_W(DATA_W)) oreg_i (
      .clk     (clk),
      .clr     (clr),
      .load    (pop),
      .drop    (drop),
      .word_in (head_word),
      .data_q  (data_q),
      .valid_q (valid_q)
   );

   dmf_flags #(.DEPTH(DEPTH)) flags_i (
      .mode       (mode_q),
      .count      (count),
      .out_valid  (valid_q),
      .ae_ofs     (ae_ofs),
      .af_ofs     (af_ofs),
      .sts_a      (empty_or_rdy),
      .sts_b      (full_or_room),
      .half       (half_full),
      .near_empty (almost_empty),
      .near_full  (almost_full)
   );

   assign q_out = out_en_n ? '0 : data_q;
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk
   import dmf_pkg::*;
#(
   parameter int DATA_W = 9,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              mst_rst_n,
   input logic              prt_rst_n,
   input logic              wr_en_n,
   input logic              rd_en_n,
   input logic              rewind_n,
   input dmf_mode_e         mode_q,
   input logic [CW-1:0]     count,
   input logic [AW-1:0]     wr_ptr,
   input logic [AW-1:0]     rd_ptr,
   input logic [DATA_W-1:0] data_q,
   input logic              empty_or_rdy
);
   localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

   a_r7_master_clears: assert property (@(posedge clk)
      !mst_rst_n |=> (count == '0 && rd_ptr == '0 && wr_ptr == '0 && data_q == '0))
      else $error("R7 master reset did not clear state");

   a_r1_mode_held: assert property (@(posedge clk) disable iff (!mst_rst_n)
      mst_rst_n |=> $stable(mode_q))
      else $error("R1 mode changed outside master reset");

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!mst_rst_n)
      count <= FULL_C)
      else $error("R9 occupancy above depth");

   a_r9_full_write_ignored: assert property (@(posedge clk) disable iff (!mst_rst_n)
      (prt_rst_n && rewind_n && rd_en_n && !wr_en_n && count == FULL_C)
      |=> (count == FULL_C && $stable(wr_ptr)))
      else $error("R9 write at full was accepted");

   a_r10_rewind: assert property (@(posedge clk) disable iff (!mst_rst_n)
      (prt_rst_n && !rewind_n) |=> (rd_ptr == '0 && count == CW'($past(wr_ptr))))
      else $error("R10 rewind did not restore read side");

   a_r2_std_hold: assert property (@(posedge clk) disable iff (!mst_rst_n)
      (mode_q == MODE_STD && prt_rst_n && rd_en_n) |=> $stable(data_q))
      else $error("R2 output changed without a read");

   a_r4_ready_has_data: assert property (@(posedge clk) disable iff (!mst_rst_n)
      (mode_q == MODE_FALL && empty_or_rdy) |-> (count != '0))
      else $error("R4 output valid with nothing stored");

   a_r12_balanced: assert property (@(posedge clk) disable iff (!mst_rst_n)
      (mode_q == MODE_STD && prt_rst_n && rewind_n && !wr_en_n && !rd_en_n &&
       count != '0 && count != FULL_C) |=> $stable(count))
      else $error("R12 simultaneous read and write changed occupancy");
endmodule

bind dual_mode_fifo dmf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk          (clk),
   .mst_rst_n    (mst_rst_n),
   .prt_rst_n    (prt_rst_n),
   .wr_en_n      (wr_en_n),
   .rd_en_n      (rd_en_n),
   .rewind_n     (rewind_n),
   .mode_q       (mode_q),
   .count        (count),
   .wr_ptr       (wr_ptr),
   .rd_ptr       (rd_ptr),
   .data_q       (data_q),
   .empty_or_rdy (empty_or_rdy)
);

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb_top;
   localparam int  CLK_P  = 10;
   localparam int  DW     = 9;
   localparam int  D      = 16;
   localparam int  AW     = $clog2(D);

   logic          clk = 1'b0;
   logic          mst_n = 1'b0, prt_n = 1'b1, fsel = 1'b0;
   logic          wen_n = 1'b1, ren_n = 1'b1, rew_n = 1'b1, oe_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] aeo = AW'(3), afo = AW'(4);
   logic [DW-1:0] q;
   logic          fa, fb, fh, fae, faf;

   int nvec = 0;
   int nfail = 0;

   // reference state
   logic [DW-1:0] m_mem [D];
   int            m_wr, m_rd, m_cnt;
   logic          m_valid, m_mode;
   logic [DW-1:0] m_dout;

   always #(CLK_P/2) clk = ~clk;

   dual_mode_fifo #(.DATA_W(DW), .DEPTH(D)) dut_i (
      .clk(clk), .mst_rst_n(mst_n), .prt_rst_n(prt_n), .fall_sel(fsel),
      .wr_en_n(wen_n), .wr_data(din), .rd_en_n(ren_n), .rewind_n(rew_n),
      .out_en_n(oe_n), .ae_ofs(aeo), .af_ofs(afo), .q_out(q),
      .empty_or_rdy(fa), .full_or_room(fb), .half_full(fh),
      .almost_empty(fae), .almost_full(faf)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_update();
      bit wok, cons, pop;
      int memw;
      if (!mst_n) begin
         m_mode = fsel; m_wr = 0; m_rd = 0; m_cnt = 0; m_valid = 0; m_dout = '0;
      end else if (!prt_n) begin
         m_wr = 0; m_rd = 0; m_cnt = 0; m_valid = 0; m_dout = '0;
      end else if (!rew_n) begin
         m_rd = 0; m_cnt = m_wr; m_valid = 0;
      end else begin
         wok = !wen_n && (m_cnt < D);
         if (!m_mode) begin
            cons = !ren_n && (m_cnt > 0);
            if (cons) begin
               m_dout = m_mem[m_rd]; m_rd = (m_rd + 1) % D;
            end
         end else begin
            cons = !ren_n && m_valid;
            memw = m_cnt - int'(m_valid);
            pop  = (memw > 0) && (!m_valid || cons);
            if (pop) begin
               m_dout = m_mem[m_rd]; m_rd = (m_rd + 1) % D; m_valid = 1;
            end else if (cons) begin
               m_valid = 0;
            end
         end
         m_cnt = m_cnt + int'(wok) - int'(cons);
         if (wok) begin
            m_mem[m_wr] = din; m_wr = (m_wr + 1) % D;
         end
      end
   endtask

   task automatic check_all();
      int exp_a, exp_b;
      chk(m_mode ? "R3 data" : "R2 data", int'(q), oe_n ? 0 : int'(m_dout));
      exp_a = m_mode ? int'(m_valid) : int'(m_cnt == 0);
      exp_b = m_mode ? int'(m_cnt < D) : int'(m_cnt == D);
      chk("R4 flag a", int'(fa), exp_a);
      chk("R4 flag b", int'(fb), exp_b);
      chk("R5 half", int'(fh), int'(m_cnt > D/2));
      chk("R6 almost empty", int'(fae), int'(m_cnt <= int'(aeo)));
      chk("R6 almost full", int'(faf), int'(m_cnt >= D - int'(afo)));
   endtask

   // drive at negedge, let the edge act, compare at the next negedge
   task automatic step();
      @(posedge clk);
      model_update();
      @(negedge clk);
      check_all();
   endtask

   task automatic idle();
      wen_n = 1'b1; ren_n = 1'b1; rew_n = 1'b1; prt_n = 1'b1;
   endtask

   task automatic rand_run(input int n);
      for (int i = 0; i < n; i++) begin
         wen_n = ($urandom % 10) >= 6;
         ren_n = ($urandom % 10) >= 5;
         rew_n = ($urandom % 50) != 0;
         prt_n = ($urandom % 100) != 0;
         din   = DW'($urandom);
         if (i % 200 == 0) begin
            aeo = AW'($urandom); afo = AW'($urandom);
         end
         step();
      end
      idle();
   endtask

   initial begin
      #(CLK_P * 150000);
      nfail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_mode = 0; m_wr = 0; m_rd = 0; m_cnt = 0; m_valid = 0; m_dout = '0;
      @(negedge clk);
      // R7 reset state, standard mode selected
      step(); step();
      chk("R7 reset data", int'(q), 0);
      chk("R7 reset empty", int'(fa), 1);
      mst_n = 1'b1;

      // R2: write does not reach the output, read does
      din = DW'(9'h1A5); wen_n = 1'b0; step(); wen_n = 1'b1;
      chk("R2 no fall-through", int'(q), 0);
      step();
      chk("R2 still held", int'(q), 0);
      ren_n = 1'b0; step(); ren_n = 1'b1;
      chk("R2 read data", int'(q), 'h1A5);
      // R9: read at empty leaves output
      ren_n = 1'b0; step(); ren_n = 1'b1;
      chk("R9 empty read", int'(q), 'h1A5);

      // R9: fill, then an extra write is dropped
      for (int i = 0; i < D; i++) begin
         din = DW'(i * 7 + 3); wen_n = 1'b0; step();
      end
      din = DW'(9'h0FF); step(); wen_n = 1'b1;
      chk("R9 full flag", int'(fb), 1);
      // R12: read and write together at full-1 keeps occupancy
      ren_n = 1'b0; step();
      din = DW'(9'h055); wen_n = 1'b0; step(); wen_n = 1'b1; ren_n = 1'b1;
      chk("R12 balanced occupancy", int'(fb), 0);
      ren_n = 1'b0;
      for (int i = 0; i < D; i++) step();
      ren_n = 1'b1;
      chk("R9 dropped word absent", int'(q), 'h055);
      chk("R9 drained", int'(fa), 1);

      // R11: output enable gating
      oe_n = 1'b1; step();
      chk("R11 disabled output", int'(q), 0);
      oe_n = 1'b0; step();
      chk("R11 enabled output", int'(q), 'h055);

      rand_run(1500);

      // R10 directed in standard mode
      prt_n = 1'b0; step(); prt_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         din = DW'(40 + i); wen_n = 1'b0; step();
      end
      wen_n = 1'b1; ren_n = 1'b0; step(); step(); step();
      ren_n = 1'b1; rew_n = 1'b0; wen_n = 1'b0; din = DW'(9'h1FF); step();
      rew_n = 1'b1; wen_n = 1'b1;
      ren_n = 1'b0; step(); ren_n = 1'b1;
      chk("R10 reread first word", int'(q), 40);

      // R1 / R3: fall-through mode, select pin released after reset
      mst_n = 1'b0; fsel = 1'b1; step();
      mst_n = 1'b1; fsel = 1'b0;
      din = DW'(9'h0A1); wen_n = 1'b0; step(); wen_n = 1'b1;
      chk("R3 not yet ready", int'(fa), 0);
      step();
      chk("R1 mode kept after reset", int'(fa), 1);
      chk("R3 fell through", int'(q), 'h0A1);
      din = DW'(9'h0B2); wen_n = 1'b0; step(); wen_n = 1'b1; step();
      chk("R3 head held", int'(q), 'h0A1);
      ren_n = 1'b0; step();
      chk("R3 next word on read", int'(q), 'h0B2);
      step(); ren_n = 1'b1;
      chk("R3 last read drops ready", int'(fa), 0);

      // R8: partial reset keeps fall-through mode
      din = DW'(9'h0C3); wen_n = 1'b0; step(); wen_n = 1'b1;
      prt_n = 1'b0; step(); prt_n = 1'b1;
      chk("R8 cleared output", int'(q), 0);
      chk("R8 cleared ready", int'(fa), 0);
      din = DW'(9'h0D4); wen_n = 1'b0; step(); wen_n = 1'b1; step();
      chk("R8 mode kept", int'(fa), 1);
      chk("R8 data after partial reset", int'(q), 'h0D4);

      // R10 in fall-through: valid word discarded, location 0 reloaded
      rew_n = 1'b0; step(); rew_n = 1'b1;
      chk("R10 valid dropped", int'(fa), 0);
      step();
      chk("R10 reload ready", int'(fa), 1);
      chk("R10 reload data", int'(q), 'h0D4);

      rand_run(1500);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule